// File: doc/BRIEF.md
# Microwire Memory Serial Front End

This block is the slave side of a three-wire serial memory port. It watches chip select, serial clock and serial data in, all arriving synchronous to the system clock, and drives a serial data out with a separate output enable standing in for the tri-state pin. While chip select is high, zeros on the data line are skipped until a 1 marks the start of a frame. A two-bit opcode, an address field and, for programming commands, a data field follow. Field widths follow a word-organisation input: 128 words of 16 bits, or 256 bytes.

Reads are served directly from the port. The front end puts a word index on its read-address output and takes the word from a combinational array read port. It sends a dummy zero and then the word, most significant bit first, and keeps moving on to the following word for as long as chip select stays high. Every other command goes to a separate array sequencer through a valid/ready command port. A command is offered only when chip select falls after a complete frame. Once offered, its fields hold until the sequencer takes it. If a second command completes while the first is still waiting and not being taken in that cycle, the second command is dropped. After a programming command has been handed over, raising chip select shows the sequencer's busy flag on the data output. Shifting a 1 in ends that display.

Top module: `mw_serial_front`

## Requirements
- R1: After reset, `do_oe_o` and `cmd_valid_o` are 0.
- R2: While chip select is high, 0 bits sampled before a frame are ignored. The first 1 sampled on a serial-clock rise is the start bit.
- R3: The two bits after the start bit are the opcode, first bit received in the high position. 10 is read, 01 writes one location (`cmd_op_o` = 1), 11 erases one location (`cmd_op_o` = 2).
- R4: For opcode 00, the two most significant bits of the address field select the command. 11 is write-enable (code 5), 00 is write-disable (code 6), 10 is erase-all (code 3), and 01 is write-all (code 4), which takes a data field. The other address bits are ignored.
- R5: With `org_x16_i` = 1, the address field is 8 bits and the data field is 16 bits, and the word index (`cmd_addr_o`, `rd_addr_o`) is the low 7 address bits. With `org_x16_i` = 0, the address field is 9 bits, the data field is 8 bits (placed in `cmd_data_o[7:0]`, with the upper bits 0), and the index is the low 8 address bits. All fields are received MSB first.
- R6: On a read, one clock after the serial-clock rise that samples the last address bit, `do_oe_o` is 1 and `do_o` is 0 (the dummy bit). Each later serial-clock rise presents the next data bit, MSB first, one clock after that rise.
- R7: While chip select stays high, a read runs on into the following word. The index wraps from the last location (127 or 255) to 0.
- R8: `do_oe_o` is 0 except during read data or status display. It is 0 one clock after chip select falls.
- R9: After a write, erase, erase-all or write-all has been accepted, raising chip select sets `do_oe_o` to 1 one clock later. `do_o` is then 0 while `prog_busy_i` is 1 and 1 when it is 0.
- R10: During status display, a 0 shifted in leaves the display on. A 1 shifted in turns `do_oe_o` off one clock after the next serial-clock fall.
- R11: `cmd_valid_o` rises one clock after chip select falls following a complete frame. A frame cut short by chip select falling produces no command.
- R12: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, `cmd_op_o`, `cmd_addr_o` and `cmd_data_o` hold. A frame that completes while an earlier command is still waiting, and not being taken in that cycle, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org_x16_i | input | 1 | 1: 16-bit words, 0: bytes |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Output enable for serial data out |
| rd_addr_o | output | 8 | Word index for the array read port |
| rd_data_i | input | 16 | Array read data (bytes in bits 7:0) |
| prog_busy_i | input | 1 | Sequencer program cycle in progress |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Sequencer takes the command |
| cmd_op_o | output | 3 | Command code |
| cmd_addr_o | output | 8 | Command word index |
| cmd_data_o | output | 16 | Command write data |

## Verification
Serial-clock and chip-select edges are found by comparing each input with its value at the previous system-clock edge. Each result is therefore due exactly one system clock after the edge of the clock in which the input changed: read bits and the dummy bit follow a rise, the status turn-off follows a fall, and the output-enable clear, command offer and status turn-on follow chip-select edges. The bench changes inputs on falling system-clock edges and samples outputs on the following falling edge. Each sample falls half a period after the register update it checks. The busy display is checked at two points, once with the sequencer model busy and once after it has finished.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_WRITE     = 3'd1,
    CMD_ERASE     = 3'd2,
    CMD_ERASE_ALL = 3'd3,
    CMD_WRITE_ALL = 3'd4,
    CMD_WR_EN     = 3'd5,
    CMD_WR_DIS    = 3'd6
  } mw_cmd_e;

  typedef enum logic [2:0] {
    FS_IDLE, FS_OPC, FS_ADDR, FS_DATA, FS_READ, FS_DONE
  } mw_fs_e;
endpackage

// File: rtl/mw_sk_edges.sv
module mw_sk_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  output logic sk_rise,
  output logic sk_fall,
  output logic cs_rise,
  output logic cs_fall
);
  logic sk_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk_i;
      cs_q <= cs_i;
    end
  end

  assign sk_rise = cs_i & sk_i & ~sk_q;
  assign sk_fall = cs_i & ~sk_i & sk_q;
  assign cs_rise = cs_i & ~cs_q;
  assign cs_fall = ~cs_i & cs_q;
endmodule

// File: rtl/mw_frame_dec.sv
module mw_frame_dec
  import mw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              org_x16,
  input  logic              sk_rise,
  input  logic              cs_fall,
  input  logic              di,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              cmd_ready,
  output logic              rd_active,
  output logic              rd_bit,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cmd_valid,
  output mw_cmd_e           cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              prog_commit
);
  localparam int RAW_W = ADDR_W + 1;
  localparam int MAXL  = (RAW_W > DATA_W) ? RAW_W : DATA_W;
  localparam int CNT_W = $clog2(MAXL + 1);
  localparam int BS_W  = $clog2(DATA_W);
  localparam int HALF  = DATA_W / 2;

  mw_fs_e             state;
  mw_cmd_e            pend_op;
  logic [1:0]         opc;
  logic [RAW_W-1:0]   raw, raw_nx;
  logic [DATA_W-1:0]  dat, dmask;
  logic [CNT_W-1:0]   cnt, addr_len, data_len, top_bit;
  logic [BS_W-1:0]    bit_sel;
  logic [ADDR_W-1:0]  raw_idx, nx_idx, rd_inc;
  logic [1:0]         nx_sub;
  logic               accept;

  always_comb begin
    raw_nx   = {raw[RAW_W-2:0], di};
    addr_len = org_x16 ? CNT_W'(RAW_W - 1) : CNT_W'(RAW_W);
    data_len = org_x16 ? CNT_W'(DATA_W) : CNT_W'(HALF);
    top_bit  = org_x16 ? CNT_W'(DATA_W - 1) : CNT_W'(HALF - 1);
    bit_sel  = BS_W'(top_bit - cnt);
    dmask    = org_x16 ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
    raw_idx  = org_x16 ? {1'b0, raw[ADDR_W-2:0]} : raw[ADDR_W-1:0];
    nx_idx   = org_x16 ? {1'b0, raw_nx[ADDR_W-2:0]} : raw_nx[ADDR_W-1:0];
    nx_sub   = org_x16 ? raw_nx[ADDR_W-1 -: 2] : raw_nx[RAW_W-1 -: 2];
    rd_inc   = org_x16 ? {1'b0, rd_addr[ADDR_W-2:0] + 1'b1} : rd_addr + 1'b1;
    accept   = (state == FS_DONE) && (!cmd_valid || cmd_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= FS_IDLE;
      pend_op     <= CMD_NONE;
      opc         <= '0;
      raw         <= '0;
      dat         <= '0;
      cnt         <= '0;
      rd_active   <= 1'b0;
      rd_bit      <= 1'b0;
      rd_addr     <= '0;
      cmd_valid   <= 1'b0;
      cmd_op      <= CMD_NONE;
      cmd_addr    <= '0;
      cmd_data    <= '0;
      prog_commit <= 1'b0;
    end else begin
      prog_commit <= 1'b0;
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
      if (cs_fall) begin
        if (accept) begin
          cmd_valid   <= 1'b1;
          cmd_op      <= pend_op;
          cmd_addr    <= raw_idx;
          cmd_data    <= dat & dmask;
          prog_commit <= (pend_op != CMD_WR_EN) && (pend_op != CMD_WR_DIS);
        end
        state     <= FS_IDLE;
        rd_active <= 1'b0;
      end else if (sk_rise) begin
        unique case (state)
          FS_IDLE: if (di) begin
            state <= FS_OPC;
            cnt   <= '0;
            raw   <= '0;
            dat   <= '0;
          end
          FS_OPC: begin
            opc <= {opc[0], di};
            if (cnt == CNT_W'(1)) begin
              state <= FS_ADDR;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          FS_ADDR: begin
            raw <= raw_nx;
            if (cnt == addr_len - 1'b1) begin
              cnt <= '0;
              unique case (opc)
                2'b10: begin
                  state     <= FS_READ;
                  rd_active <= 1'b1;
                  rd_bit    <= 1'b0;
                  rd_addr   <= nx_idx;
                end
                2'b01: begin state <= FS_DATA; pend_op <= CMD_WRITE; end
                2'b11: begin state <= FS_DONE; pend_op <= CMD_ERASE; end
                default: unique case (nx_sub)
                  2'b11: begin state <= FS_DONE; pend_op <= CMD_WR_EN;     end
                  2'b00: begin state <= FS_DONE; pend_op <= CMD_WR_DIS;    end
                  2'b10: begin state <= FS_DONE; pend_op <= CMD_ERASE_ALL; end
                  default: begin state <= FS_DATA; pend_op <= CMD_WRITE_ALL; end
                endcase
              endcase
            end else cnt <= cnt + 1'b1;
          end
          FS_DATA: begin
            dat <= {dat[DATA_W-2:0], di};
            if (cnt == data_len - 1'b1) state <= FS_DONE;
            else cnt <= cnt + 1'b1;
          end
          FS_READ: begin
            rd_bit <= rd_data[bit_sel];
            if (cnt == data_len - 1'b1) begin
              cnt     <= '0;
              rd_addr <= rd_inc;
            end else cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_status_ctl.sv
module mw_status_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_rise,
  input  logic cs_fall,
  input  logic sk_rise,
  input  logic sk_fall,
  input  logic di,
  input  logic prog_commit,
  output logic stat_mode
);
  logic armed, exit_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      stat_mode <= 1'b0;
      exit_pend <= 1'b0;
    end else begin
      if (prog_commit) armed <= 1'b1;
      if (cs_fall) begin
        stat_mode <= 1'b0;
        exit_pend <= 1'b0;
      end else if (cs_rise) begin
        stat_mode <= armed;
      end else if (stat_mode) begin
        if (sk_rise && di) exit_pend <= 1'b1;
        if (sk_fall && exit_pend) begin
          stat_mode <= 1'b0;
          exit_pend <= 1'b0;
          armed     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mw_serial_front.sv
module mw_serial_front
  import mw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  input  logic              org_x16_i,
  output logic              do_o,
  output logic              do_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              prog_busy_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [2:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  logic    sk_rise, sk_fall, cs_rise, cs_fall;
  logic    rd_active, rd_bit, prog_commit, stat_mode;
  mw_cmd_e op_e;

  mw_sk_edges u_edges (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i),
    .sk_rise(sk_rise), .sk_fall(sk_fall), .cs_rise(cs_rise), .cs_fall(cs_fall)
  );

  mw_frame_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .org_x16(org_x16_i), .sk_rise(sk_rise),
    .cs_fall(cs_fall), .di(di_i), .rd_data(rd_data_i), .cmd_ready(cmd_ready_i),
    .rd_active(rd_active), .rd_bit(rd_bit), .rd_addr(rd_addr_o),
    .cmd_valid(cmd_valid_o), .cmd_op(op_e), .cmd_addr(cmd_addr_o),
    .cmd_data(cmd_data_o), .prog_commit(prog_commit)
  );

  mw_status_ctl u_stat (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sk_rise(sk_rise), .sk_fall(sk_fall), .di(di_i),
    .prog_commit(prog_commit), .stat_mode(stat_mode)
  );

  assign cmd_op_o = op_e;
  assign do_oe_o  = rd_active | stat_mode;
  assign do_o     = rd_active ? rd_bit : (stat_mode & ~prog_busy_i);
endmodule

// File: rtl/mw_serial_front_chk.sv
module mw_serial_front_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_i,
  input logic              org_x16_i,
  input logic              do_o,
  input logic              do_oe_o,
  input logic              rd_active,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [2:0]        cmd_op_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [DATA_W-1:0] cmd_data_o
);
  logic [ADDR_W-1:0] prev_addr, step_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_addr <= '0;
    else        prev_addr <= rd_addr_o;
  end

  always_comb begin
    step_exp = prev_addr + 1'b1;
    if (org_x16_i) step_exp[ADDR_W-1] = 1'b0;
  end

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    do_oe_o |-> $past(cs_i)); // R8

  AST_READ_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> (do_oe_o && !do_o)); // R6

  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && $past(rd_active) && !$stable(rd_addr_o)) |-> rd_addr_o == step_exp); // R7

  AST_COMMIT_AT_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid_o) |-> (!$past(cs_i) && $past(cs_i, 2))); // R11

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_op_o) &&
      $stable(cmd_addr_o) && $stable(cmd_data_o))); // R12
endmodule

bind mw_serial_front mw_serial_front_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mw_serial_front_bench.sv
module mw_serial_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic        do_v, do_oe;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  logic        busy;
  logic        cmd_valid, cmd_ready = 1'b1;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_addr;
  logic [15:0] cmd_data;

  int total = 0, bad = 0, cap_cnt = 0, busy_cnt = 0;
  logic [2:0]  cap_op = '0;
  logic [7:0]  cap_addr = '0;
  logic [15:0] cap_data = '0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  mw_serial_front u_mw_serial_front (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .org_x16_i(org),
    .do_o(do_v), .do_oe_o(do_oe), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .prog_busy_i(busy), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_op_o(cmd_op), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
  );

  function automatic logic [15:0] pat16(input logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction
  function automatic logic [7:0] pat8(input logic [7:0] a);
    return a ^ 8'h3C;
  endfunction

  assign rd_data = org ? pat16(rd_addr) : {8'h00, pat8(rd_addr)};
  assign busy    = (busy_cnt != 0);

  // sequencer model
  always @(posedge clk) begin
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (cmd_valid && cmd_ready) begin
      cap_cnt  <= cap_cnt + 1;
      cap_op   <= cmd_op;
      cap_addr <= cmd_addr;
      cap_data <= cmd_data;
      if (cmd_op >= 3'd1 && cmd_op <= 3'd4) busy_cnt <= 12;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b, output logic oe_r, output logic do_r, output logic oe_f);
    @(negedge clk); di = b; sk = 1'b1;
    @(negedge clk); oe_r = do_oe; do_r = do_v;
    @(negedge clk); sk = 1'b0;
    @(negedge clk); oe_f = do_oe;
  endtask

  task automatic send(input logic [15:0] v, input int n);
    logic a, b, c;
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i], a, b, c);
  endtask

  task automatic cs_up();
    @(negedge clk); cs = 1'b1;
    @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk); cs = 1'b0; di = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // read frame: start + opcode 10, address, then nwords words
  task automatic t_read(input logic x16, input logic [8:0] raw, input int nwords);
    logic oe_r, do_r, oe_f;
    logic [15:0] got;
    logic [7:0] idx;
    int alen, dlen;
    org = x16;
    alen = x16 ? 8 : 9;
    dlen = x16 ? 16 : 8;
    idx = x16 ? {1'b0, raw[6:0]} : raw[7:0];
    cs_up();
    send(16'b110, 3);
    for (int i = alen - 1; i >= 0; i--) sk_bit(raw[i], oe_r, do_r, oe_f);
    check(oe_r && !do_r, "R6 dummy bit", {oe_r, do_r}, 2'b10);
    for (int w = 0; w < nwords; w++) begin
      got = '0;
      for (int i = 0; i < dlen; i++) begin
        sk_bit(1'b0, oe_r, do_r, oe_f);
        got = {got[14:0], do_r};
      end
      check(got == (x16 ? pat16(idx) : {8'h00, pat8(idx)}), "R5/R7 read word", got,
            x16 ? pat16(idx) : {8'h00, pat8(idx)});
      idx = x16 ? {1'b0, idx[6:0] + 7'd1} : idx + 8'd1;
    end
    cs_down();
    check(!do_oe, "R8 oe off after cs fall", do_oe, 0);
  endtask

  task automatic expect_cmd(input int prev, input logic [2:0] op, input logic [7:0] a,
                            input logic [15:0] d, input string req);
    idle(3);
    check(cap_cnt == prev + 1, req, cap_cnt, prev + 1);
    check(cap_op == op && cap_addr == a && cap_data == d, req,
          {cap_op, cap_addr, cap_data}, {op, a, d});
  endtask

  task automatic t_write_status();
    int prev;
    logic oe_r, do_r, oe_f;
    org = 1'b1; prev = cap_cnt;
    cs_up();
    send(16'b000, 3);                 // R2 leading zeros
    send(16'b101, 3);                 // start + opcode 01
    send(16'h0092, 8);                // top bit don't care -> index 0x12
    send(16'hBEEF, 16);
    check(!cmd_valid && cap_cnt == prev, "R11 no command before cs fall", cap_cnt, prev);
    cs_down();
    expect_cmd(prev, 3'd1, 8'h12, 16'hBEEF, "R2 R3 write decode");
    cs_up();
    check(do_oe && !do_v, "R9 busy shown", {do_oe, do_v}, 2'b10);
    idle(20);
    check(do_oe && do_v, "R9 ready shown", {do_oe, do_v}, 2'b11);
    sk_bit(1'b0, oe_r, do_r, oe_f);
    check(oe_f, "R10 zero keeps status", oe_f, 1);
    sk_bit(1'b1, oe_r, do_r, oe_f);
    check(oe_r && !oe_f, "R10 one ends status at fall", {oe_r, oe_f}, 2'b10);
    cs_down();
  endtask

  task automatic t_frame(input logic x16, input logic [2:0] hdr, input logic [8:0] raw,
                         input int dlen, input logic [15:0] d);
    org = x16;
    cs_up();
    send({13'd0, hdr}, 3);
    send({7'd0, raw}, x16 ? 8 : 9);
    if (dlen > 0) send(d, dlen);
    cs_down();
  endtask

  task automatic t_erase_x8();
    int prev = cap_cnt;
    t_frame(1'b0, 3'b111, 9'h1A5, 0, 16'h0);
    expect_cmd(prev, 3'd2, 8'hA5, 16'h0000, "R3 R5 erase x8");
  endtask

  task automatic t_special();
    int prev;
    prev = cap_cnt; t_frame(1'b1, 3'b100, 9'h0C5, 0, 16'h0);
    expect_cmd(prev, 3'd5, 8'h45, 16'h0, "R4 write enable");
    prev = cap_cnt; t_frame(1'b1, 3'b100, 9'h03F, 0, 16'h0);
    expect_cmd(prev, 3'd6, 8'h3F, 16'h0, "R4 write disable");
    prev = cap_cnt; t_frame(1'b1, 3'b100, 9'h080, 0, 16'h0);
    expect_cmd(prev, 3'd3, 8'h00, 16'h0, "R4 erase all");
    prev = cap_cnt; t_frame(1'b1, 3'b100, 9'h040, 16, 16'h1234);
    expect_cmd(prev, 3'd4, 8'h40, 16'h1234, "R4 write all x16");
    prev = cap_cnt; t_frame(1'b0, 3'b100, 9'h0AA, 8, 16'h00C3);
    expect_cmd(prev, 3'd4, 8'hAA, 16'h00C3, "R4 R5 write all x8");
  endtask

  task automatic t_abort();
    int prev = cap_cnt;
    org = 1'b1;
    cs_up();
    send(16'b101, 3);
    send(16'h0033, 8);
    send(16'h00AB, 8);                // only half the data field
    cs_down();
    idle(4);
    check(!cmd_valid && cap_cnt == prev, "R11 short frame dropped", cap_cnt, prev);
    check(!do_oe, "R8 oe stays off", do_oe, 0);
  endtask

  task automatic t_backpressure();
    int prev = cap_cnt;
    @(negedge clk); cmd_ready = 1'b0;
    t_frame(1'b1, 3'b100, 9'h0C0, 0, 16'h0);
    idle(5);
    check(cmd_valid && cmd_op == 3'd5, "R12 held while not ready", {cmd_valid, cmd_op}, 4'hD);
    t_frame(1'b1, 3'b100, 9'h000, 0, 16'h0);
    check(cmd_valid && cmd_op == 3'd5, "R12 second frame dropped", cmd_op, 5);
    @(negedge clk); cmd_ready = 1'b1;
    idle(5);
    check(cap_cnt == prev + 1 && cap_op == 3'd5 && !cmd_valid, "R12 one command taken",
          cap_cnt, prev + 1);
  endtask

  initial begin
    idle(3);
    check(!do_oe && !cmd_valid, "R1 reset state", {do_oe, cmd_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    check(!do_oe && !cmd_valid, "R1 after reset release", {do_oe, cmd_valid}, 0);
    cs_up();
    idle(2);
    check(!do_oe, "R8 idle cs high no drive", do_oe, 0);
    cs_down();
    t_read(1'b1, 9'h005, 2);
    t_read(1'b1, 9'h0FF, 2);          // R7 wrap 127 -> 0
    t_read(1'b0, 9'h0FF, 2);          // R7 wrap 255 -> 0
    t_write_status();
    t_erase_x8();
    t_special();
    t_abort();
    t_backpressure();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule